// File: doc/BRIEF.md
# DMA Channel Control and Fault Status Register Bank

This block is the software-visible register bank of a 64-channel DMA controller. It holds a control word that drives the arbiter's mode pins. It also holds per-channel bit vectors for request enable, error-interrupt enable, interrupt request, error flag, done and interrupt routing. Each vector is read and written as two 32-bit words. The high word covers channels 63 to 32, with channel c at bit c-32. The low word covers channels 31 to 0, with channel c at bit c.

Software changes a single channel's bit without a read-modify-write. It writes the channel number to one of eight byte-wide command ports. The same mechanism launches a channel: a write to the start command port produces a one-cycle start pulse towards that channel's engine. The channel engines report completions and faults. The first fault is latched in an error status word together with its channel number and cause, and it is kept there until software clears it. A single interrupt line summarizes pending interrupt requests and enabled error flags.

The bus is a simple synchronous one. A request with a write strobe is applied at the next clock edge. A read request returns its data on `rdata_o` from the following cycle.

Top module: `dma_chan_regs`

## Requirements
- R1: After reset every register word reads zero, `irq_o` is low, `start_o` is all zero and the control outputs are low.
- R2: The control word (word address 0) keeps only bit 31 (clock gating enable, drives `clk_gate_en_o`), bit 3 (round-robin group arbitration, drives `rr_group_o`) and bit 2 (round-robin channel arbitration, drives `rr_chan_o`). All other bits read zero.
- R3: The request-enable words (address 2 high, 3 low) and the error-interrupt-enable words (address 4 high, 5 low) are read/write. `req_en_o` presents the request-enable vector.
- R4: The command ports take a channel number in `wdata_i[5:0]` and ignore all higher data bits. Address 16 sets a request enable and 17 clears one. Address 18 sets an error-interrupt enable and 19 clears one. No other channel's bit changes.
- R5: A write to address 22 (start command) pulses `start_o` for the selected channel, high for exactly the one cycle after the write. No other bit of `start_o` rises.
- R6: `ch_done_i` sets the channel's done flag (address 14 high, 15 low). In the same clock edge, it sets the interrupt request bit when `ch_int_en_i` is high for that channel. A write to address 23 clears one channel's done flag.
- R7: The interrupt request words (6 high, 7 low) and error flag words (8 high, 9 low) clear the bits written as one and keep the bits written as zero. Address 20 clears one channel's interrupt bit and address 21 clears one channel's error flag. A set arriving in the same cycle as a clear wins.
- R8: A fault report (`err_valid_i`) sets the error flag of channel `err_ch_i`. If the status word (address 1) is not valid, the report is captured there: bit 31 valid, bit 15 `err_cause_i[9]` (group priority), bit 14 `err_cause_i[8]` (channel priority), bits 13:8 the channel, bits 7:0 `err_cause_i[7:0]` (source address, source offset, destination address, destination offset, count configuration, scatter/gather configuration, source bus, destination bus, from bit 7 down). All other bits are zero.
- R9: While the status word is valid, later faults only set their error flags. Any write to address 1 clears the word, except that a fault in the same cycle is captured instead.
- R10: `irq_o` is high, from the cycle after the state changes, exactly while any interrupt request bit is set or any error flag is set together with its error-interrupt enable.
- R11: Addresses 10 (high) and 11 (low) read the live `hw_req_i` vector. Addresses 12 (high) and 13 (low) are read/write routing-select words driving `int_route_o`.
- R12: Read data appears on `rdata_o` in the cycle after a read request. Command ports and unmapped addresses read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access request |
| we_i | input | 1 | Write strobe for the access |
| addr_i | input | 5 | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, one cycle after the request |
| ch_done_i | input | 64 | Per-channel completion pulses |
| ch_int_en_i | input | 64 | Per-channel descriptor interrupt-on-completion state |
| hw_req_i | input | 64 | Per-channel hardware request status |
| err_valid_i | input | 1 | Fault report strobe |
| err_ch_i | input | 6 | Channel of the fault |
| err_cause_i | input | 10 | Fault cause bits |
| start_o | output | 64 | Per-channel start pulses |
| req_en_o | output | 64 | Request enable vector |
| int_route_o | output | 64 | Interrupt routing-select vector |
| clk_gate_en_o | output | 1 | Dynamic clock gating enable |
| rr_group_o | output | 1 | Round-robin group arbitration select |
| rr_chan_o | output | 1 | Round-robin channel arbitration select |
| irq_o | output | 1 | Combined interrupt |

## Verification
The hardest cases to reach are the collisions between the engines and software. These are a completion landing in the same edge as a write-one-to-clear of that interrupt bit, and a fault arriving in the same edge as the clearing write to the status word. The bench drives `ch_done_i` or `err_valid_i` in the very cycle it presents the bus write. It then reads back the interrupt word or the status word and expects the new event to survive. A second fault while the status word still holds the first one is also injected, to show that only the flag word moves.

// File: rtl/dcr_pkg.sv
package dcr_pkg;
  localparam int unsigned ADDR_W    = 5;
  localparam int unsigned NUM_WORDS = 2 ** ADDR_W;
  localparam int unsigned CAUSE_W   = 10;

  localparam int unsigned A_CTRL   = 0;
  localparam int unsigned A_ESTAT  = 1;
  localparam int unsigned A_RQEN_H = 2;
  localparam int unsigned A_RQEN_L = 3;
  localparam int unsigned A_EIEN_H = 4;
  localparam int unsigned A_EIEN_L = 5;
  localparam int unsigned A_INT_H  = 6;
  localparam int unsigned A_INT_L  = 7;
  localparam int unsigned A_ERR_H  = 8;
  localparam int unsigned A_ERR_L  = 9;
  localparam int unsigned A_HWRQ_H = 10;
  localparam int unsigned A_HWRQ_L = 11;
  localparam int unsigned A_RSEL_H = 12;
  localparam int unsigned A_RSEL_L = 13;
  localparam int unsigned A_DONE_H = 14;
  localparam int unsigned A_DONE_L = 15;
  localparam int unsigned A_SET_RQEN = 16;
  localparam int unsigned A_CLR_RQEN = 17;
  localparam int unsigned A_SET_EIEN = 18;
  localparam int unsigned A_CLR_EIEN = 19;
  localparam int unsigned A_CLR_INT  = 20;
  localparam int unsigned A_CLR_ERR  = 21;
  localparam int unsigned A_START    = 22;
  localparam int unsigned A_CLR_DONE = 23;

  typedef struct packed {
    logic set_rqen;
    logic clr_rqen;
    logic set_eien;
    logic clr_eien;
    logic clr_int;
    logic clr_err;
    logic start;
    logic clr_done;
  } cmd_t;

  typedef struct packed {
    logic gate;
    logic rr_group;
    logic rr_chan;
  } ctrl_t;
endpackage

// File: rtl/dcr_cmd_dec.sv
module dcr_cmd_dec
  import dcr_pkg::*;
#(
  parameter int unsigned NUM_CH = 64,
  parameter int unsigned CH_W   = 6
) (
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CH_W-1:0]   ch_sel_i,
  output logic [NUM_WORDS-1:0] wr_o,
  output cmd_t              cmd_o,
  output logic [NUM_CH-1:0] ch_mask_o
);
  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_wr
    assign wr_o[w] = req_i & we_i & (addr_i == ADDR_W'(w));
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_mask
    assign ch_mask_o[c] = (ch_sel_i == CH_W'(c));
  end

  assign cmd_o.set_rqen = wr_o[A_SET_RQEN];
  assign cmd_o.clr_rqen = wr_o[A_CLR_RQEN];
  assign cmd_o.set_eien = wr_o[A_SET_EIEN];
  assign cmd_o.clr_eien = wr_o[A_CLR_EIEN];
  assign cmd_o.clr_int  = wr_o[A_CLR_INT];
  assign cmd_o.clr_err  = wr_o[A_CLR_ERR];
  assign cmd_o.start    = wr_o[A_START];
  assign cmd_o.clr_done = wr_o[A_CLR_DONE];
endmodule

// File: rtl/dcr_flag_vec.sv
module dcr_flag_vec #(
  parameter int unsigned N = 64
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] ld_en_i,
  input  logic [N-1:0] ld_val_i,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q_o
);
  logic [N-1:0] q_q;

  // priority per bit: set over clear over load
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= '0;
    else         q_q <= (((q_q & ~ld_en_i) | (ld_val_i & ld_en_i)) & ~clr_i) | set_i;
  end

  assign q_o = q_q;

  assert_set_wins_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i != '0) |=> ((q_o & $past(set_i)) == $past(set_i)))
    else $error("set bit lost");
endmodule

// File: rtl/dcr_err_cap.sv
module dcr_err_cap
  import dcr_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CH_W   = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               fault_i,
  input  logic [CH_W-1:0]    ch_i,
  input  logic [CAUSE_W-1:0] cause_i,
  input  logic               clr_i,
  output logic [DATA_W-1:0]  stat_o
);
  logic               vld_q;
  logic [CH_W-1:0]    ch_q;
  logic [CAUSE_W-1:0] cause_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q   <= 1'b0;
      ch_q    <= '0;
      cause_q <= '0;
    end else if (fault_i && (!vld_q || clr_i)) begin
      vld_q   <= 1'b1;
      ch_q    <= ch_i;
      cause_q <= cause_i;
    end else if (clr_i) begin
      vld_q   <= 1'b0;
      ch_q    <= '0;
      cause_q <= '0;
    end
  end

  always_comb begin
    stat_o              = '0;
    stat_o[DATA_W-1]    = vld_q;
    stat_o[15:14]       = cause_q[9:8];
    stat_o[8 +: CH_W]   = ch_q;
    stat_o[7:0]         = cause_q[7:0];
  end

  assert_first_fault_kept_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_q && !clr_i) |=> $stable(stat_o))
    else $error("captured fault overwritten");
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dcr_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned NUM_CH = 2 * DATA_W,
  localparam int unsigned CH_W   = $clog2(NUM_CH)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  rdata_o,
  input  logic [NUM_CH-1:0]  ch_done_i,
  input  logic [NUM_CH-1:0]  ch_int_en_i,
  input  logic [NUM_CH-1:0]  hw_req_i,
  input  logic               err_valid_i,
  input  logic [CH_W-1:0]    err_ch_i,
  input  logic [CAUSE_W-1:0] err_cause_i,
  output logic [NUM_CH-1:0]  start_o,
  output logic [NUM_CH-1:0]  req_en_o,
  output logic [NUM_CH-1:0]  int_route_o,
  output logic               clk_gate_en_o,
  output logic               rr_group_o,
  output logic               rr_chan_o,
  output logic               irq_o
);
  logic [NUM_WORDS-1:0] wr;
  cmd_t                 cmd;
  logic [NUM_CH-1:0]    ch_mask;

  dcr_cmd_dec #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_dec (
    .req_i     (req_i),
    .we_i      (we_i),
    .addr_i    (addr_i),
    .ch_sel_i  (wdata_i[CH_W-1:0]),
    .wr_o      (wr),
    .cmd_o     (cmd),
    .ch_mask_o (ch_mask)
  );

  function automatic logic [NUM_CH-1:0] halves(input logic hi, input logic lo);
    return {{DATA_W{hi}}, {DATA_W{lo}}};
  endfunction

  function automatic logic [NUM_CH-1:0] sel(input logic en, input logic [NUM_CH-1:0] m);
    return en ? m : '0;
  endfunction

  logic [NUM_CH-1:0] wide_wd;
  logic [NUM_CH-1:0] err_onehot;
  assign wide_wd    = {wdata_i, wdata_i};
  assign err_onehot = sel(err_valid_i, NUM_CH'(1) << err_ch_i);

  logic [NUM_CH-1:0] rqen_q, eien_q, int_q, err_q, done_q, rsel_q;

  dcr_flag_vec #(.N(NUM_CH)) u_rqen (
    .clk_i, .rst_ni,
    .ld_en_i  (halves(wr[A_RQEN_H], wr[A_RQEN_L])),
    .ld_val_i (wide_wd),
    .set_i    (sel(cmd.set_rqen, ch_mask)),
    .clr_i    (sel(cmd.clr_rqen, ch_mask)),
    .q_o      (rqen_q)
  );

  dcr_flag_vec #(.N(NUM_CH)) u_eien (
    .clk_i, .rst_ni,
    .ld_en_i  (halves(wr[A_EIEN_H], wr[A_EIEN_L])),
    .ld_val_i (wide_wd),
    .set_i    (sel(cmd.set_eien, ch_mask)),
    .clr_i    (sel(cmd.clr_eien, ch_mask)),
    .q_o      (eien_q)
  );

  dcr_flag_vec #(.N(NUM_CH)) u_int (
    .clk_i, .rst_ni,
    .ld_en_i  ('0),
    .ld_val_i ('0),
    .set_i    (ch_done_i & ch_int_en_i),
    .clr_i    ((halves(wr[A_INT_H], wr[A_INT_L]) & wide_wd) | sel(cmd.clr_int, ch_mask)),
    .q_o      (int_q)
  );

  dcr_flag_vec #(.N(NUM_CH)) u_err (
    .clk_i, .rst_ni,
    .ld_en_i  ('0),
    .ld_val_i ('0),
    .set_i    (err_onehot),
    .clr_i    ((halves(wr[A_ERR_H], wr[A_ERR_L]) & wide_wd) | sel(cmd.clr_err, ch_mask)),
    .q_o      (err_q)
  );

  dcr_flag_vec #(.N(NUM_CH)) u_done (
    .clk_i, .rst_ni,
    .ld_en_i  ('0),
    .ld_val_i ('0),
    .set_i    (ch_done_i),
    .clr_i    (sel(cmd.clr_done, ch_mask)),
    .q_o      (done_q)
  );

  dcr_flag_vec #(.N(NUM_CH)) u_rsel (
    .clk_i, .rst_ni,
    .ld_en_i  (halves(wr[A_RSEL_H], wr[A_RSEL_L])),
    .ld_val_i (wide_wd),
    .set_i    ('0),
    .clr_i    ('0),
    .q_o      (rsel_q)
  );

  logic [DATA_W-1:0] estat;

  dcr_err_cap #(.DATA_W(DATA_W), .CH_W(CH_W)) u_ecap (
    .clk_i, .rst_ni,
    .fault_i (err_valid_i),
    .ch_i    (err_ch_i),
    .cause_i (err_cause_i),
    .clr_i   (wr[A_ESTAT]),
    .stat_o  (estat)
  );

  ctrl_t             ctrl_q;
  logic [NUM_CH-1:0] start_q;
  logic [DATA_W-1:0] rdata_q, rd_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '0;
      start_q <= '0;
      rdata_q <= '0;
    end else begin
      if (wr[A_CTRL]) ctrl_q <= '{gate: wdata_i[DATA_W-1], rr_group: wdata_i[3], rr_chan: wdata_i[2]};
      start_q <= sel(cmd.start, ch_mask);
      if (req_i && !we_i) rdata_q <= rd_n;
    end
  end

  always_comb begin
    rd_n = '0;
    case (addr_i)
      ADDR_W'(A_CTRL): begin
        rd_n[DATA_W-1] = ctrl_q.gate;
        rd_n[3]        = ctrl_q.rr_group;
        rd_n[2]        = ctrl_q.rr_chan;
      end
      ADDR_W'(A_ESTAT):  rd_n = estat;
      ADDR_W'(A_RQEN_H): rd_n = rqen_q[NUM_CH-1:DATA_W];
      ADDR_W'(A_RQEN_L): rd_n = rqen_q[DATA_W-1:0];
      ADDR_W'(A_EIEN_H): rd_n = eien_q[NUM_CH-1:DATA_W];
      ADDR_W'(A_EIEN_L): rd_n = eien_q[DATA_W-1:0];
      ADDR_W'(A_INT_H):  rd_n = int_q[NUM_CH-1:DATA_W];
      ADDR_W'(A_INT_L):  rd_n = int_q[DATA_W-1:0];
      ADDR_W'(A_ERR_H):  rd_n = err_q[NUM_CH-1:DATA_W];
      ADDR_W'(A_ERR_L):  rd_n = err_q[DATA_W-1:0];
      ADDR_W'(A_HWRQ_H): rd_n = hw_req_i[NUM_CH-1:DATA_W];
      ADDR_W'(A_HWRQ_L): rd_n = hw_req_i[DATA_W-1:0];
      ADDR_W'(A_RSEL_H): rd_n = rsel_q[NUM_CH-1:DATA_W];
      ADDR_W'(A_RSEL_L): rd_n = rsel_q[DATA_W-1:0];
      ADDR_W'(A_DONE_H): rd_n = done_q[NUM_CH-1:DATA_W];
      ADDR_W'(A_DONE_L): rd_n = done_q[DATA_W-1:0];
      default:           rd_n = '0;
    endcase
  end

  assign rdata_o       = rdata_q;
  assign start_o       = start_q;
  assign req_en_o      = rqen_q;
  assign int_route_o   = rsel_q;
  assign clk_gate_en_o = ctrl_q.gate;
  assign rr_group_o    = ctrl_q.rr_group;
  assign rr_chan_o     = ctrl_q.rr_chan;
  assign irq_o         = (|int_q) | (|(err_q & eien_q));

  assert_start_single_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i == ADDR_W'(A_START)) |=> ($countones(start_o) == 1))
    else $error("start pulse not single");

  assert_start_quiet_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && we_i && addr_i == ADDR_W'(A_START)) |=> (start_o == '0))
    else $error("spurious start");

  assert_irq_on_done_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((ch_done_i & ch_int_en_i) != '0) |=> irq_o)
    else $error("completion without interrupt");

  assert_fault_flag_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_valid_i |=> (irq_o || !$past(eien_q[err_ch_i]) || $past(wr[A_EIEN_H] | wr[A_EIEN_L] | cmd.clr_eien)))
    else $error("enabled fault without interrupt");
endmodule

// File: tb/sim_dma_chan_regs.sv
`timescale 1ns/1ps
module sim_dma_chan_regs;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0, we_i = 1'b0;
  logic [4:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [63:0] ch_done_i = '0, ch_int_en_i = '0, hw_req_i = '0;
  logic        err_valid_i = 1'b0;
  logic [5:0]  err_ch_i = '0;
  logic [9:0]  err_cause_i = '0;
  logic [63:0] start_o, req_en_o, int_route_o;
  logic        clk_gate_en_o, rr_group_o, rr_chan_o, irq_o;

  int n_vec = 0, n_bad = 0;
  bit finished = 0;

  always #4 clk_i = ~clk_i;

  dma_chan_regs u0 (.*);

  task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic wr(input int a, input logic [31:0] d);
    req_i = 1; we_i = 1; addr_i = 5'(a); wdata_i = d;
    @(posedge clk_i); @(negedge clk_i);
    req_i = 0; we_i = 0; wdata_i = '0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    req_i = 1; we_i = 0; addr_i = 5'(a);
    @(posedge clk_i); @(negedge clk_i);
    d = rdata_o; req_i = 0;
  endtask

  task automatic rchk(input string rq, input int a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(rq, {32'h0, d}, {32'h0, exp});
  endtask

  task automatic t_reset;
    for (int a = 0; a < 16; a++) rchk("R1 reset word", a, 32'h0);
    chk("R1 irq", {63'h0, irq_o}, 64'h0);
    chk("R1 start", start_o, 64'h0);
    chk("R1 ctrl outs", {61'h0, clk_gate_en_o, rr_group_o, rr_chan_o}, 64'h0);
  endtask

  task automatic t_ctrl;
    wr(0, 32'hFFFF_FFFF);
    rchk("R2 ctrl read", 0, 32'h8000_000C);
    chk("R2 ctrl outs", {61'h0, clk_gate_en_o, rr_group_o, rr_chan_o}, 64'h7);
    wr(0, 32'h8000_0004);
    chk("R2 ctrl outs partial", {61'h0, clk_gate_en_o, rr_group_o, rr_chan_o}, 64'h5);
    wr(0, 32'h0);
  endtask

  task automatic t_enables;
    wr(2, 32'hA5A5_0001);
    wr(3, 32'h1234_5678);
    chk("R3 req_en_o", req_en_o, 64'hA5A5_0001_1234_5678);
    rchk("R3 rqen hi", 2, 32'hA5A5_0001);
    wr(4, 32'h0000_00F0);
    wr(5, 32'h8000_0000);
    rchk("R3 eien hi", 4, 32'h0000_00F0);
    rchk("R3 eien lo", 5, 32'h8000_0000);
  endtask

  task automatic t_cmds;
    wr(16, 32'hFFFF_FFC7);  // upper bits ignored: channel 7
    chk("R4 set rqen ch7", req_en_o, 64'hA5A5_0001_1234_56F8);
    wr(17, 32'd63);
    chk("R4 clr rqen ch63", req_en_o, 64'h25A5_0001_1234_56F8);
    wr(18, 32'd33);
    rchk("R4 set eien ch33", 4, 32'h0000_00F2);
    wr(19, 32'd31);
    rchk("R4 clr eien ch31", 5, 32'h0);
  endtask

  task automatic t_start;
    wr(22, 32'd45);
    chk("R5 start pulse", start_o, 64'h1 << 45);
    @(negedge clk_i);
    chk("R5 start ends", start_o, 64'h0);
  endtask

  task automatic t_done_int;
    ch_int_en_i = 64'h1 << 10;
    ch_done_i   = (64'h1 << 10) | (64'h1 << 50);
    @(posedge clk_i); @(negedge clk_i);
    ch_done_i = '0;
    chk("R10 irq after done", {63'h0, irq_o}, 64'h1);
    rchk("R6 done lo", 15, 32'h0000_0400);
    rchk("R6 done hi", 14, 32'h0004_0000);
    rchk("R6 int lo", 7, 32'h0000_0400);
    rchk("R6 int hi not enabled", 6, 32'h0);
    wr(23, 32'd50);
    rchk("R6 clr done ch50", 14, 32'h0);
    rchk("R6 done ch10 kept", 15, 32'h0000_0400);
  endtask

  task automatic t_w1c;
    wr(7, 32'h0);
    rchk("R7 zero write keeps", 7, 32'h0000_0400);
    wr(7, 32'h0000_0400);
    rchk("R7 w1c clears", 7, 32'h0);
    chk("R10 irq drops", {63'h0, irq_o}, 64'h0);
    // completion in the same edge as the clearing write
    ch_done_i = 64'h1 << 10;
    req_i = 1; we_i = 1; addr_i = 5'd7; wdata_i = 32'h0000_0400;
    @(posedge clk_i); @(negedge clk_i);
    req_i = 0; we_i = 0; wdata_i = '0; ch_done_i = '0;
    rchk("R7 set wins", 7, 32'h0000_0400);
    wr(20, 32'd10);
    rchk("R7 clr int cmd", 7, 32'h0);
    ch_int_en_i = '0;
  endtask

  task automatic fault(input logic [5:0] ch, input logic [9:0] cause);
    err_valid_i = 1; err_ch_i = ch; err_cause_i = cause;
    @(posedge clk_i); @(negedge clk_i);
    err_valid_i = 0;
  endtask

  task automatic t_err;
    wr(4, 32'h0); wr(5, 32'h0);
    fault(6'd40, 10'h201);
    rchk("R8 status capture", 1, 32'h8000_A801);
    rchk("R8 err flag hi", 8, 32'h0000_0100);
    chk("R10 no irq when disabled", {63'h0, irq_o}, 64'h0);
    wr(4, 32'h0000_0100);
    chk("R10 irq when enabled", {63'h0, irq_o}, 64'h1);
    fault(6'd3, 10'h0FF);
    rchk("R9 first fault kept", 1, 32'h8000_A801);
    rchk("R9 later flag set", 9, 32'h0000_0008);
    wr(1, 32'h0);
    rchk("R9 status cleared", 1, 32'h0);
    // fault coinciding with clear is captured
    err_valid_i = 1; err_ch_i = 6'd5; err_cause_i = 10'h100;
    req_i = 1; we_i = 1; addr_i = 5'd1;
    @(posedge clk_i); @(negedge clk_i);
    err_valid_i = 0; req_i = 0; we_i = 0;
    rchk("R9 fault beats clear", 1, 32'h8000_4500);
    wr(21, 32'd40);
    rchk("R7 clr err cmd", 8, 32'h0);
    chk("R10 irq off after clr", {63'h0, irq_o}, 64'h0);
    wr(9, 32'hFFFF_FFFF);
    rchk("R7 err w1c", 9, 32'h0);
  endtask

  task automatic t_misc;
    hw_req_i = 64'hDEAD_BEEF_0123_4567;
    rchk("R11 hwreq hi", 10, 32'hDEAD_BEEF);
    rchk("R11 hwreq lo", 11, 32'h0123_4567);
    wr(12, 32'h0F0F_0000);
    wr(13, 32'h0000_F0F0);
    chk("R11 route out", int_route_o, 64'h0F0F_0000_0000_F0F0);
    rchk("R11 route read", 12, 32'h0F0F_0000);
    rchk("R12 cmd port reads zero", 16, 32'h0);
    rchk("R12 unmapped reads zero", 31, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    t_reset;
    t_ctrl;
    t_enables;
    t_cmds;
    t_start;
    t_done_int;
    t_w1c;
    t_err;
    t_misc;
    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!finished) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule